// File: doc/BRIEF.md
# Parallel-Compare Dictionary Match Engine

The engine finds every dictionary key that starts at each position of a stream of 16-bit character codes. Keys are held column-wise: one memory for each of the `KEYN` character positions. All columns share a single read address, so one access yields a whole key. The engine keeps a `KEYN`-deep window over the text. Window slot 1 holds the character at the current text position. The low `IXB` bits of that character select a bucket in a first-character table. The table gives the start address of the bucket and its entry count. The engine then steps the shared address through that range. At each address it compares all window slots with the stored key at the same time. Each full agreement produces a one-cycle hit.

The dictionary and the bucket table are loaded through plain write ports. Text arrives over a valid/ready handshake and ends with a reserved end code. After the last hit for the final position, the engine clears itself and accepts a new text. The engine outputs only the dictionary address and the text position of each hit. Later stages that select among candidates are not part of this block.

Top module: `dict_match_engine`

## Requirements
- R1: After reset, `hit_valid` is 0 and `txt_ready` is 1: the engine is ready to fill its window.
- R2: A dictionary write stores all `KEYN` characters of a key at one address. Character position k occupies bits `[16k+15:16k]` of `dict_wkey`. An index write stores a start address and a count for one bucket. A later write to the same bucket replaces the earlier values.
- R3: A hit is reported only when every one of the `KEYN` window slots agrees with the stored key. A difference in any single position, including the last, gives no hit.
- R4: The stored code `PAD` (default 16'hFFFE) matches any window character, including the end code that fills the window near the end of the text.
- R5: Only the addresses `start .. start+count-1` of the bucket are examined. The bucket is selected by the low `IXB` bits of the character in slot 1. An entry outside that range never hits, even if its key would match.
- R6: Each hit gives `hit_addr` and `hit_pos`, the zero-based text index of the slot-1 character. Hits for one position come in ascending address order.
- R7: Each examined address takes exactly three clock cycles, so hits at adjacent addresses are 3 cycles apart. A bucket with count 0 causes no dictionary access and no hit.
- R8: The end code `EOT` (default 16'hFFFF) is the last character taken. After it is accepted, `txt_ready` stays low and the window is back-filled with `EOT`. When `EOT` reaches slot 1, the engine returns to its post-reset state, with position 0 and `txt_ready` high.
- R9: When `txt_valid` is low, the engine waits at a fill or shift step. Gaps in the input do not change the hits reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dict_we | input | 1 | Dictionary write strobe |
| dict_waddr | input | AW | Dictionary write address |
| dict_wkey | input | KEYN*CW | Key to write; position k at bits [CW*k +: CW] |
| idx_we | input | 1 | Bucket table write strobe |
| idx_waddr | input | IXB | Bucket number |
| idx_wstart | input | AW | First dictionary address of the bucket |
| idx_wcount | input | AW+1 | Number of entries in the bucket |
| txt_valid | input | 1 | Text character offered |
| txt_char | input | CW | Text character code |
| txt_ready | output | 1 | Engine takes the offered character |
| hit_valid | output | 1 | One-cycle hit pulse |
| hit_addr | output | AW | Dictionary address of the hit |
| hit_pos | output | PW | Text position of the hit |

## Verification
On every cycle, the assertions check four things. Hits at the same position rise in address. Two hits are never on adjacent cycles. The position only counts up by one or returns to zero. The window holds still during an address sweep. A further assertion checks that `txt_ready` drops once the end code has been taken. The bench scenarios are needed to show the behaviours that depend on stored content: which keys match under padding, the exact bucket boundaries, the three-cycle spacing, and that the hits are the same under input gaps and after a restart.

// File: rtl/dict_match_engine.sv
module dict_match_engine #(
  parameter int CW    = 16,
  parameter int KEYN  = 8,
  parameter int DEPTH = 64,
  parameter int IXB   = 8,
  parameter int PW    = 16,
  parameter logic [CW-1:0] PAD = 16'hFFFE,
  parameter logic [CW-1:0] EOT = 16'hFFFF,
  localparam int AW   = $clog2(DEPTH),
  localparam int NW   = AW + 1,
  localparam int IXN  = 1 << IXB,
  localparam int FW   = $clog2(KEYN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dict_we,
  input  logic [AW-1:0]      dict_waddr,
  input  logic [KEYN*CW-1:0] dict_wkey,
  input  logic               idx_we,
  input  logic [IXB-1:0]     idx_waddr,
  input  logic [AW-1:0]      idx_wstart,
  input  logic [NW-1:0]      idx_wcount,
  input  logic               txt_valid,
  input  logic [CW-1:0]      txt_char,
  output logic               txt_ready,
  output logic               hit_valid,
  output logic [AW-1:0]      hit_addr,
  output logic [PW-1:0]      hit_pos
);

  typedef enum logic [1:0] {S_FILL, S_LOOK, S_EVAL, S_SHIFT} st_t;

  st_t             st;
  logic [FW-1:0]   fcnt;
  logic            eot_seen;
  logic [CW-1:0]   win [KEYN];
  logic [PW-1:0]   pos;
  logic [AW-1:0]   addr;
  logic [NW-1:0]   rem;
  logic [1:0]      ph;
  logic            eq_q;
  logic [KEYN-1:0] slot_ok;

  logic [AW-1:0]   ix_start [IXN];
  logic [NW-1:0]   ix_cnt   [IXN];

  wire             in_phase = (st == S_FILL) || (st == S_SHIFT);
  wire             shift_go = in_phase && (eot_seen || txt_valid);
  wire [CW-1:0]    new_ch   = eot_seen ? EOT : txt_char;
  wire [IXB-1:0]   bucket   = win[0][IXB-1:0];
  wire [AW-1:0]    b_start  = ix_start[bucket];
  wire [NW-1:0]    b_cnt    = ix_cnt[bucket];

  assign txt_ready = in_phase && !eot_seen;

  always_ff @(posedge clk)
    if (idx_we) begin
      ix_start[idx_waddr] <= idx_wstart;
      ix_cnt[idx_waddr]   <= idx_wcount;
    end

  for (genvar g = 0; g < KEYN; g++) begin : g_col
    logic [CW-1:0] col [DEPTH];
    logic [CW-1:0] kq;
    always_ff @(posedge clk) begin
      if (dict_we) col[dict_waddr] <= dict_wkey[g*CW +: CW];
      if (st == S_EVAL && ph == 2'd0) kq <= col[addr];
    end
    assign slot_ok[g] = (kq == PAD) || (kq == win[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_FILL;
      fcnt      <= '0;
      eot_seen  <= 1'b0;
      pos       <= '0;
      addr      <= '0;
      rem       <= '0;
      ph        <= '0;
      eq_q      <= 1'b0;
      hit_valid <= 1'b0;
      hit_addr  <= '0;
      hit_pos   <= '0;
      for (int i = 0; i < KEYN; i++) win[i] <= EOT;
    end else begin
      hit_valid <= 1'b0;
      if (shift_go) begin
        for (int i = 0; i < KEYN - 1; i++) win[i] <= win[i+1];
        win[KEYN-1] <= new_ch;
        if (new_ch == EOT) eot_seen <= 1'b1;
      end
      case (st)
        S_FILL:
          if (shift_go) begin
            fcnt <= fcnt + 1'b1;
            if (fcnt == FW'(KEYN - 1)) st <= S_LOOK;
          end
        S_LOOK:
          if (win[0] == EOT) begin
            st       <= S_FILL;
            fcnt     <= '0;
            eot_seen <= 1'b0;
            pos      <= '0;
          end else if (b_cnt == '0) begin
            st <= S_SHIFT;
          end else begin
            addr <= b_start;
            rem  <= b_cnt;
            ph   <= 2'd0;
            st   <= S_EVAL;
          end
        S_EVAL:
          case (ph)
            2'd0: ph <= 2'd1;
            2'd1: begin
              eq_q <= &slot_ok;
              ph   <= 2'd2;
            end
            default: begin
              hit_valid <= eq_q;
              hit_addr  <= addr;
              hit_pos   <= pos;
              addr      <= addr + 1'b1;
              rem       <= rem - 1'b1;
              ph        <= 2'd0;
              if (rem == NW'(1)) st <= S_SHIFT;
            end
          endcase
        default:
          if (shift_go) begin
            pos <= pos + 1'b1;
            st  <= S_LOOK;
          end
      endcase
    end
  end

  logic          prv_ok;
  logic [AW-1:0] prv_addr;
  logic [PW-1:0] prv_pos;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prv_ok   <= 1'b0;
      prv_addr <= '0;
      prv_pos  <= '0;
    end else if (st == S_FILL) begin
      prv_ok <= 1'b0;
    end else if (hit_valid) begin
      prv_ok   <= 1'b1;
      prv_addr <= hit_addr;
      prv_pos  <= hit_pos;
    end

  p_addr_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && prv_ok && hit_pos == prv_pos) |-> hit_addr > prv_addr);

  p_hit_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> !hit_valid);

  p_pos_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != $past(pos)) |-> (pos == $past(pos) + 1'b1 || pos == '0));

  p_win_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL) |=> (st != S_EVAL || $stable(win[0])) && (st != S_EVAL || $stable(win[KEYN-1])));

  p_end_stops_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txt_valid && txt_ready && txt_char == EOT) |=> !txt_ready);

endmodule

// File: tb/sim_dict_match_engine.sv
module sim_dict_match_engine;
  localparam int CW = 16, KEYN = 8, DEPTH = 64, IXB = 8, PW = 16;
  localparam int AW = $clog2(DEPTH);
  localparam logic [15:0] PADC = 16'hFFFE, EOTC = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dict_we = 0, idx_we = 0, txt_valid = 0;
  logic [AW-1:0] dict_waddr = '0, idx_wstart = '0;
  logic [KEYN*CW-1:0] dict_wkey = '0;
  logic [IXB-1:0] idx_waddr = '0;
  logic [AW:0] idx_wcount = '0;
  logic [CW-1:0] txt_char = '0;
  logic txt_ready, hit_valid;
  logic [AW-1:0] hit_addr;
  logic [PW-1:0] hit_pos;

  dict_match_engine u0 (.clk, .rst_n, .dict_we, .dict_waddr, .dict_wkey,
    .idx_we, .idx_waddr, .idx_wstart, .idx_wcount, .txt_valid, .txt_char,
    .txt_ready, .hit_valid, .hit_addr, .hit_pos);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, nh = 0;
  int h_addr [64], h_pos [64], h_cyc [64];
  logic [15:0] tbuf [40];
  int tlen;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (hit_valid && nh < 64) begin
    h_addr[nh] = int'(hit_addr); h_pos[nh] = int'(hit_pos); h_cyc[nh] = cyc; nh++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_key(int a, string s);
    @(negedge clk);
    dict_we = 1; dict_waddr = AW'(a);
    for (int i = 0; i < KEYN; i++)
      dict_wkey[i*CW +: CW] = (i < s.len()) ? {8'h00, s[i]} : PADC;
    @(negedge clk); dict_we = 0;
  endtask

  task automatic wr_idx(int b, int st, int n);
    @(negedge clk);
    idx_we = 1; idx_waddr = IXB'(b); idx_wstart = AW'(st); idx_wcount = (AW+1)'(n);
    @(negedge clk); idx_we = 0;
  endtask

  task automatic set_text(string s);
    for (int i = 0; i < s.len(); i++) tbuf[i] = {8'h00, s[i]};
    tbuf[s.len()] = EOTC;
    tlen = s.len() + 1;
  endtask

  task automatic run(int gap);
    logic acc;
    nh = 0;
    for (int i = 0; i < tlen; i++) begin
      txt_valid = 0;
      repeat (gap) @(negedge clk);
      txt_valid = 1; txt_char = tbuf[i];
      do begin
        acc = txt_ready;
        @(negedge clk);
      end while (!acc);
    end
    txt_valid = 0;
    chk("R8 ready low after end code", int'(txt_ready), 0);
    while (!txt_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 hit_valid at reset", int'(hit_valid), 0);
    chk("R1 txt_ready at reset", int'(txt_ready), 1);
  endtask

  task automatic t_full_match;
    set_text("ABCDEFGH"); run(0);
    chk("R3/R4 hit count", nh, 5);
    chk("R6 hit0 addr", h_addr[0], 0); chk("R6 hit0 pos", h_pos[0], 0);
    chk("R3 hit1 addr", h_addr[1], 1);
    chk("R3 full key hit addr", h_addr[2], 3); chk("R6 hit2 pos", h_pos[2], 0);
    chk("R4 pad vs end code addr", h_addr[3], 4); chk("R6 hit3 pos", h_pos[3], 1);
    chk("R4 hit4 addr", h_addr[4], 5); chk("R6 hit4 pos", h_pos[4], 1);
    chk("R7 adjacent spacing", h_cyc[1] - h_cyc[0], 3);
    chk("R7 skip one spacing", h_cyc[2] - h_cyc[1], 6);
    chk("R8 ready after restart", int'(txt_ready), 1);
  endtask

  task automatic t_last_mismatch;
    set_text("ABCDEFGX"); run(0);
    chk("R3 last slot differs count", nh, 4);
    chk("R3 hit addr1", h_addr[1], 1);
    chk("R8 restart pos", h_pos[0], 0);
    chk("R6 hit2 addr", h_addr[2], 4); chk("R6 hit2 pos", h_pos[2], 1);
  endtask

  task automatic t_zero_count;
    set_text("DDD"); run(0);
    chk("R7 empty bucket no hit", nh, 0);
  endtask

  task automatic t_range;
    wr_idx(8'h42, 5, 1);
    set_text("BC"); run(0);
    chk("R5 narrowed range count", nh, 1);
    chk("R5 only in-range addr", h_addr[0], 5);
    chk("R2 rewritten index pos", h_pos[0], 0);
    wr_idx(8'h42, 4, 2);
  endtask

  task automatic t_gaps;
    set_text("ABCDEFGH"); run(5);
    chk("R9 gapped count", nh, 5);
    chk("R9 gapped addr2", h_addr[2], 3);
    chk("R9 gapped pos3", h_pos[3], 1);
    chk("R9 gapped spacing", h_cyc[1] - h_cyc[0], 3);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int b = 0; b < (1 << IXB); b++) wr_idx(b, 0, 0);
    wr_key(0, "AB"); wr_key(1, "ABC"); wr_key(2, "ABD"); wr_key(3, "ABCDEFGH");
    wr_key(4, "B"); wr_key(5, "BC"); wr_key(6, "CZ");
    wr_idx(8'h41, 0, 4); wr_idx(8'h42, 4, 2); wr_idx(8'h43, 6, 1);
    t_full_match();
    t_last_mismatch();
    t_zero_count();
    t_range();
    t_gaps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule